// File: doc/BRIEF.md
# Centre-Aligned PWM Timer with Pin Override

This block is a 16-bit up/down timer. It produces centre-aligned pulse-width modulation on up to four compare channels. A prescaler divides the peripheral clock. Each time the prescaler fires, the counter takes one step. It climbs from zero to the active period value, turns around, and descends back towards zero. One full up/down cycle lasts twice the period value in prescaled ticks. The output frequency is therefore the clock frequency divided by 2·N·period.

The period and compare values are written into holding inputs. They reach the active registers only when the counter returns to zero, so a waveform never changes partway through a cycle. While the prescaler is switched off, the counter is held at zero and the holding values pass straight through.

Each channel's waveform can take over one general-purpose pin from the port's output latch. A fixed parameter sets which pins the channels drive. Each pin has its own invert control.

Top module: `cpwm_timer`

## Requirements
- R1: While running, the counter visits 0, 1, …, TOP, then TOP-1, …, 1, and then 0 again. One period is 2·TOP counter steps, and the count never exceeds TOP.
- R2: Prescaler select encoding: 0 stops the timer and clears the counter to 0. Codes 1 to 7 make the counter step once every 1, 2, 4, 8, 64, 256 or 1024 clocks respectively.
- R3: A period value below 3 is loaded as 3, so the smallest period is 6 steps. Values up to 0xFFFF are accepted unchanged.
- R4: Period and compare inputs are copied to the active registers only when the counter steps from 1 to 0, or on any clock while the timer is stopped. A change made in mid-cycle does not alter the cycle in progress.
- R5: `upd_stb` is high for exactly one clock: the first clock in which the count is 0 after a descent. It does not pulse when the timer starts.
- R6: A channel waveform is high when count < compare. A compare of 0 keeps it low for the whole period. A compare ≥ TOP keeps it high for the whole period. Otherwise it is high for 2·compare−1 steps of each period.
- R7: `match_stb[c]` is high for one clock on entering a counter step where count equals channel c's active compare value. This gives 2 pulses per period for 0 < compare < TOP, 1 pulse for compare 0 or TOP, and 0 pulses above TOP.
- R8: A mapped pin takes its channel's waveform when three conditions hold: the channel enable bit is set, `wave_mode` is 1, and the pin direction bit is 1 (output). In that case it drives the waveform XOR the pin's invert bit. Otherwise it drives the port latch bit, and its invert bit has no effect.
- R9: Channel c maps to pin PIN_BASE+c. Pins outside PIN_BASE…PIN_BASE+NUM_CH−1 always drive the port latch bit. The defaults are channels 0–3 on pins 0–3; a two-channel variant uses pins 4–5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_sel | input | 3 | Prescaler select (0 = stopped) |
| per_in | input | CNT_W | Buffered period (TOP) value |
| cmp_in | input | NUM_CH·CNT_W | Buffered compare values, channel c at bits c·CNT_W upward |
| cmp_en | input | NUM_CH | Per-channel override enable |
| wave_mode | input | 1 | Waveform generation mode selected |
| pin_dir | input | NUM_PINS | Pin direction, 1 = output |
| pin_inv | input | NUM_PINS | Per-pin waveform invert |
| port_out | input | NUM_PINS | Port output latch values |
| pin_drive | output | NUM_PINS | Value driven onto each pin |
| count | output | CNT_W | Current counter value |
| upd_stb | output | 1 | Update (bottom) strobe |
| match_stb | output | NUM_CH | Per-channel compare-match strobe |

## Verification
The main function is tested with directed settings that sit on the edges. These are compare values of 0, 1, TOP and above TOP; the minimum period; a period below the minimum; and the slow prescaler codes. Random periods, compares and prescaler codes are then added. For each setting the bench measures one full period in clocks, the high time of each pin and the number of match pulses. A wrong period separates turnaround and prescaler errors, the high time separates compare-edge errors, and the pulse count separates strobe errors. A period input changed just after a bottom event shows whether the buffering holds the cycle in progress. Random combinations of enable, mode, direction, invert and latch bits, on two instances with different pin maps, show whether any single gating term or the pin map is wrong.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    localparam int unsigned PSC_W = 10;

    typedef enum logic [2:0] {
        PSC_OFF   = 3'd0,
        PSC_D1    = 3'd1,
        PSC_D2    = 3'd2,
        PSC_D4    = 3'd3,
        PSC_D8    = 3'd4,
        PSC_D64   = 3'd5,
        PSC_D256  = 3'd6,
        PSC_D1024 = 3'd7
    } psc_sel_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    // terminal value of the divider for each select code (N - 1)
    function automatic logic [PSC_W-1:0] psc_limit(input logic [2:0] sel);
        logic [PSC_W-1:0] lim;
        case (psc_sel_e'(sel))
            PSC_D2:    lim = PSC_W'(1);
            PSC_D4:    lim = PSC_W'(3);
            PSC_D8:    lim = PSC_W'(7);
            PSC_D64:   lim = PSC_W'(63);
            PSC_D256:  lim = PSC_W'(255);
            PSC_D1024: lim = PSC_W'(1023);
            default:   lim = '0;
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler
    import cpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       run,
    output logic       tick
);

    typedef struct packed {
        logic [PSC_W-1:0] div;
    } psc_state_t;

    psc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        run  = (sel != PSC_OFF);
        tick = run && (st_q.div >= psc_limit(sel));
        if (!run || tick) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_DIV1_EVERY_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == PSC_D1 && $past(sel) == PSC_D1) |-> tick); // R2

endmodule

// File: rtl/cpwm_updown.sv
module cpwm_updown
    import cpwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] per_in,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next,
    output logic [CNT_W-1:0] per_act,
    output logic             load,
    output logic             upd
);

    localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(3);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        cnt_dir_e         dir;
        logic [CNT_W-1:0] per;
        logic             upd;
    } ud_state_t;

    ud_state_t        st_d, st_q;
    logic             bottom;
    logic [CNT_W-1:0] per_clamped;

    always_comb begin
        st_d        = st_q;
        st_d.upd    = 1'b0;
        bottom      = 1'b0;
        per_clamped = (per_in < MIN_PER) ? MIN_PER : per_in;
        if (!run) begin
            st_d.cnt = '0;
            st_d.dir = DIR_UP;
        end else if (tick) begin
            if (st_q.dir == DIR_UP) begin
                if (st_q.cnt >= st_q.per) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                    st_d.dir = DIR_DOWN;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                if (st_q.cnt <= CNT_W'(1)) begin
                    st_d.cnt = '0;
                    st_d.dir = DIR_UP;
                    bottom   = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
        load = !run || bottom;
        if (load) begin
            st_d.per = per_clamped;
        end
        st_d.upd = bottom;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.dir <= DIR_UP;
            st_q.per <= MIN_PER;
            st_q.upd <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q    = st_q.cnt;
    assign cnt_next = st_d.cnt;
    assign per_act  = st_q.per;
    assign upd      = st_q.upd;

    AST_CNT_WITHIN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.per); // R1

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == $past(st_q.cnt) + 1'b1 || st_q.cnt == $past(st_q.cnt) - 1'b1)); // R1

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(st_q.cnt)); // R2

    AST_PER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.per >= MIN_PER); // R3

    AST_PER_ONLY_AT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !st_q.upd) |-> $stable(st_q.per)); // R4

    AST_UPD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.upd |-> (st_q.cnt == '0 && st_q.dir == DIR_UP)); // R5

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [CNT_W-1:0] per_act,
    output logic             wave,
    output logic             match
);

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             match;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        if (load) begin
            st_d.cmp = cmp_in;
        end
        st_d.match = tick && (cnt_next == st_d.cmp);
        wave       = (cnt_q < st_q.cmp) || (st_q.cmp >= per_act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match = st_q.match;

    AST_MATCH_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (cnt_q == st_q.cmp)); // R7

    AST_FALL_ON_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wave) && $stable(st_q.cmp)) |-> (cnt_q == st_q.cmp)); // R6

endmodule

// File: rtl/cpwm_pinmux.sv
module cpwm_pinmux #(
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned PIN_BASE = 0
) (
    input  logic [NUM_CH-1:0]   wave,
    input  logic [NUM_CH-1:0]   cmp_en,
    input  logic                wave_mode,
    input  logic [NUM_PINS-1:0] pin_dir,
    input  logic [NUM_PINS-1:0] pin_inv,
    input  logic [NUM_PINS-1:0] port_out,
    output logic [NUM_PINS-1:0] pin_drive
);

    logic [NUM_PINS-1:0] en_at_pin;
    logic [NUM_PINS-1:0] wv_at_pin;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        if ((p >= PIN_BASE) && (p < PIN_BASE + NUM_CH)) begin : g_mapped
            assign en_at_pin[p] = cmp_en[p - PIN_BASE];
            assign wv_at_pin[p] = wave[p - PIN_BASE];
        end else begin : g_plain
            assign en_at_pin[p] = 1'b0;
            assign wv_at_pin[p] = 1'b0;
        end
        assign pin_drive[p] = (en_at_pin[p] & wave_mode & pin_dir[p])
                            ? (wv_at_pin[p] ^ pin_inv[p])
                            : port_out[p];
    end

endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned PIN_BASE = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                psc_sel,
    input  logic [CNT_W-1:0]          per_in,
    input  logic [NUM_CH*CNT_W-1:0]   cmp_in,
    input  logic [NUM_CH-1:0]         cmp_en,
    input  logic                      wave_mode,
    input  logic [NUM_PINS-1:0]       pin_dir,
    input  logic [NUM_PINS-1:0]       pin_inv,
    input  logic [NUM_PINS-1:0]       port_out,
    output logic [NUM_PINS-1:0]       pin_drive,
    output logic [CNT_W-1:0]          count,
    output logic                      upd_stb,
    output logic [NUM_CH-1:0]         match_stb
);

    logic             run;
    logic             tick;
    logic             load;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] per_act;
    logic [NUM_CH-1:0] wave;

    cpwm_prescaler u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (psc_sel),
        .run   (run),
        .tick  (tick)
    );

    cpwm_updown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .per_in   (per_in),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next),
        .per_act  (per_act),
        .load     (load),
        .upd      (upd_stb)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cpwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .tick     (tick),
            .cmp_in   (cmp_in[c*CNT_W +: CNT_W]),
            .cnt_q    (cnt_q),
            .cnt_next (cnt_next),
            .per_act  (per_act),
            .wave     (wave[c]),
            .match    (match_stb[c])
        );
    end

    cpwm_pinmux #(
        .NUM_CH   (NUM_CH),
        .NUM_PINS (NUM_PINS),
        .PIN_BASE (PIN_BASE)
    ) u_mux (
        .wave      (wave),
        .cmp_en    (cmp_en),
        .wave_mode (wave_mode),
        .pin_dir   (pin_dir),
        .pin_inv   (pin_inv),
        .port_out  (port_out),
        .pin_drive (pin_drive)
    );

    assign count = cnt_q;

    AST_LATCH_WHEN_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !wave_mode |-> (pin_drive == port_out)); // R8

endmodule

// File: tb/cpwm_timer_bench.sv
module cpwm_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  psc_sel = '0;
    logic [15:0] per_in = 16'd3;
    logic [63:0] cmp_bus = '0;
    logic [3:0]  cmp_en = '0;
    logic        wave_mode = 1'b0;
    logic [7:0]  pin_dir = '0;
    logic [7:0]  pin_inv = '0;
    logic [7:0]  port_out = '0;
    logic [7:0]  pin_drive, pin_drive_hi;
    logic [15:0] count, count_hi;
    logic        upd_stb, upd_stb_hi;
    logic [3:0]  match_stb;
    logic [1:0]  match_stb_hi;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpwm_timer u_cpwm_timer (
        .clk(clk), .rst_n(rst_n), .psc_sel(psc_sel), .per_in(per_in),
        .cmp_in(cmp_bus), .cmp_en(cmp_en), .wave_mode(wave_mode),
        .pin_dir(pin_dir), .pin_inv(pin_inv), .port_out(port_out),
        .pin_drive(pin_drive), .count(count), .upd_stb(upd_stb),
        .match_stb(match_stb)
    );

    cpwm_timer #(.NUM_CH(2), .PIN_BASE(4)) u_cpwm_timer_hi (
        .clk(clk), .rst_n(rst_n), .psc_sel(psc_sel), .per_in(per_in),
        .cmp_in(cmp_bus[31:0]), .cmp_en(cmp_en[1:0]), .wave_mode(wave_mode),
        .pin_dir(pin_dir), .pin_inv(pin_inv), .port_out(port_out),
        .pin_drive(pin_drive_hi), .count(count_hi), .upd_stb(upd_stb_hi),
        .match_stb(match_stb_hi)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual %0d cycles expected <= %0d", cyc, WD_LIMIT);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int div_of(input int sel);
        case (sel)
            1: return 1;
            2: return 2;
            3: return 4;
            4: return 8;
            5: return 64;
            6: return 256;
            default: return 1024;
        endcase
    endfunction

    function automatic int top_of(input int per);
        return (per < 3) ? 3 : per;
    endfunction

    function automatic int high_steps(input int cmpv, input int top);
        if (cmpv == 0) return 0;
        if (cmpv >= top) return 2 * top;
        return 2 * cmpv - 1;
    endfunction

    function automatic int match_count(input int cmpv, input int top);
        if (cmpv > top) return 0;
        if (cmpv == 0 || cmpv == top) return 1;
        return 2;
    endfunction

    function automatic bit wave_model(input int cnt, input int cmpv, input int top);
        return (cnt < cmpv) || (cmpv >= top);
    endfunction

    function automatic bit pin_model(input int p, input int base, input int nch,
                                     input int cnt, input int top, input int cm[4]);
        if (p >= base && p < base + nch && cmp_en[p-base] && wave_mode && pin_dir[p])
            return wave_model(cnt, cm[p-base], top) ^ pin_inv[p];
        return port_out[p];
    endfunction

    task automatic load_cmps(input int cm[4]);
        for (int c = 0; c < 4; c++) cmp_bus[c*16 +: 16] = 16'(cm[c]);
    endtask

    task automatic start(input int per, input int sel, input int cm[4]);
        @(negedge clk);
        psc_sel = 3'd0;
        per_in  = 16'(per);
        load_cmps(cm);
        @(negedge clk);
        @(negedge clk);
        psc_sel = 3'(sel);
    endtask

    task automatic wait_upd();
        @(negedge clk);
        while (!upd_stb) @(negedge clk);
    endtask

    // precondition: at a negedge where upd_stb is high; ends at the next one
    task automatic measure(input int top, input int n, input int cm[4], input string tag);
        int len = 0;
        int hi[4] = '{0, 0, 0, 0};
        int mt[4] = '{0, 0, 0, 0};
        check(count == 0, "R5", {tag, " count at update"}, count, 0);
        do begin
            for (int c = 0; c < 4; c++) begin
                hi[c] += pin_drive[c];
                mt[c] += match_stb[c];
            end
            len++;
            @(negedge clk);
        end while (!upd_stb);
        check(len == 2 * top * n, "R1", {tag, " period clocks (R2 divider)"}, len, 2 * top * n);
        for (int c = 0; c < 4; c++) begin
            check(hi[c] == high_steps(cm[c], top) * n, "R6", {tag, " high clocks"},
                  hi[c], high_steps(cm[c], top) * n);
            check(mt[c] == match_count(cm[c], top), "R7", {tag, " match pulses"},
                  mt[c], match_count(cm[c], top));
        end
    endtask

    task automatic scenario(input int per, input int sel, input int cm[4], input string tag);
        start(per, sel, cm);
        wait_upd();
        measure(top_of(per), div_of(sel), cm, tag);
    endtask

    initial begin
        int seed_v;
        int cm[4];
        int cm2[4];
        seed_v = $urandom(32'h00C0FFEE);
        port_out = 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(count == 0, "R1", "reset count", count, 0);
        check(upd_stb == 0, "R5", "reset update", upd_stb, 0);
        check(match_stb == 0, "R7", "reset match", match_stb, 0);
        check(pin_drive == port_out, "R8", "reset pins follow latch", pin_drive, port_out);

        wave_mode = 1'b1; cmp_en = 4'hF; pin_dir = 8'hFF; pin_inv = 8'h00; port_out = 8'h00;

        // directed corners
        cm = '{0, 1, 2, 3};    scenario(3, 1, cm, "min period R3");
        cm = '{0, 5, 10, 200}; scenario(10, 2, cm, "edges");
        cm = '{1, 2, 3, 0};    scenario(1, 3, cm, "clamped R3");
        cm = '{1, 2, 3, 4};    scenario(4, 7, cm, "div1024 R2");
        cm = '{3, 0, 6, 7};    scenario(6, 6, cm, "div256 R2");
        cm = '{10, 19, 20, 1}; scenario(20, 5, cm, "div64 R2");
        cm = '{40, 0, 1, 39};  scenario(40, 4, cm, "div8 R2");

        // random settings
        for (int i = 0; i < 8; i++) begin
            int per;
            int sel;
            per = int'($urandom_range(60, 3));
            sel = int'($urandom_range(4, 1));
            for (int c = 0; c < 4; c++) cm[c] = int'($urandom_range(per + 2, 0));
            scenario(per, sel, cm, "random");
        end

        // buffering: change inputs right after an update
        cm  = '{1, 4, 8, 0};
        cm2 = '{2, 5, 0, 3};
        start(8, 2, cm);
        wait_upd();
        per_in = 16'd5;
        load_cmps(cm2);
        measure(8, 2, cm, "old cycle kept R4");
        measure(5, 2, cm2, "new cycle R4");

        // stopping clears and holds the counter
        repeat (7) @(negedge clk);
        psc_sel = 3'd0;
        @(negedge clk);
        check(count == 0, "R2", "stop clears count", count, 0);
        repeat (5) @(negedge clk);
        check(count == 0, "R2", "stopped count held", count, 0);
        check(upd_stb == 0, "R5", "no update while stopped", upd_stb, 0);

        // override gating and pin map on both instances
        cm = '{2, 5, 9, 0};
        start(9, 1, cm);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            cmp_en    = 4'($urandom);
            wave_mode = 1'($urandom);
            pin_dir   = 8'($urandom);
            pin_inv   = 8'($urandom);
            port_out  = 8'($urandom);
            #1;
            for (int p = 0; p < 8; p++) begin
                bit e0;
                bit e1;
                e0 = pin_model(p, 0, 4, int'(count), 9, cm);
                e1 = pin_model(p, 4, 2, int'(count_hi), 9, cm);
                check(pin_drive[p] == e0, (p < 4) ? "R8" : "R9", "pin base0",
                      pin_drive[p], e0);
                check(pin_drive_hi[p] == e1, (p >= 4 && p < 6) ? "R8" : "R9", "pin base4",
                      pin_drive_hi[p], e1);
            end
        end

        summary();
        $finish;
    end

endmodule